// File: doc/BRIEF.md
# Bridge Link Status Field Synchronizer

This block keeps the negotiated-width and current-speed fields of a bridge port's 16-bit link status register in line with the device attached below the port. When a sync strobe arrives, it looks at a device-present flag and at the link status word the downstream device reports. If a device is present, each reported field is checked against the bridge's own link capability word. A value above the capability is clamped down to it, and a value of zero is replaced by the smallest legal encoding. If no device is present, both fields are reloaded straight from the capability word.

Only the two link fields are ever written. The remaining status bits keep the value they were given at reset, and the other bits of the downstream word are never copied. The strobe, the flag and both input words are plain control inputs sampled on the strobe cycle, with no handshake. Link training and speed negotiation are handled elsewhere.

Top module: `link_sta_sync`

## Requirements
- R1: Field layout: current speed sits in bits 3:0 and negotiated width in bits 9:4 of both the status register and the downstream word. The capability word holds the supported speed in bits 3:0 and the maximum width in bits 9:4, and its other bits are ignored.
- R2: While reset is asserted, and after it, the status register holds the parameter RESET_STATUS (default 16'hA411).
- R3: On a strobe with the present flag low, the width field takes the capability's maximum width and the speed field takes the capability's supported speed, even when these are zero.
- R4: On a strobe with a device present, a reported width greater than the capability's maximum width is stored as the maximum width.
- R5: On a strobe with a device present, a reported width of zero (and not above the maximum) is stored as 1, the x1 code.
- R6: On a strobe with a device present, a reported speed greater than the capability's supported speed is stored as the supported speed.
- R7: On a strobe with a device present, a reported speed of zero (and not above the supported speed) is stored as 1, the 2.5 GT/s code.
- R8: On a strobe with a device present, a nonzero reported value that does not exceed its capability field is stored unchanged, including a value equal to the limit.
- R9: Status bits 15:10 never change after reset, and the downstream word's bits 15:10 have no effect on the register.
- R10: The register takes its new value at the first rising clock edge where the strobe is high. While the strobe is low, the register does not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Sync strobe; the fields update at this edge |
| dev_present_i | input | 1 | High when a downstream device is attached |
| ds_sta_i | input | 16 | Link status word reported by the downstream device |
| cap_i | input | 32 | Bridge link capability word |
| lnk_sta_o | output | 16 | Bridge link status register |

## Verification
The embedded properties check on every cycle that the register holds still without a strobe and that bits 15:10 never move. They also check that each clamp, default and absent-device reload lands on the cycle after the strobe, as an exact value taken from the sampled inputs. Only the bench scenarios can show that the chosen encodings are right. These include the odd corner of a zero capability against a zero report, and equality with the limit passing through untouched. They also show that unrelated bits in both input words really are ignored, and that a reset in mid-run restores the default word.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  localparam int STA_W   = 16;
  localparam int CAP_W   = 32;
  localparam int SPD_LSB = 0;
  localparam int SPD_W   = 4;
  localparam int WID_LSB = 4;
  localparam int WID_W   = 6;
  localparam int MIN_SPD = 1;  // 2.5 GT/s code
  localparam int MIN_WID = 1;  // x1 code
endpackage

// File: rtl/lsync_field_fix.sv
// Clamp-or-default rule for one link field.
module lsync_field_fix #(
  parameter int W        = 4,
  parameter int MIN_CODE = 1
) (
  input  logic         present_i,
  input  logic [W-1:0] rep_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] fix_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN_CODE);

  always_comb begin
    if (!present_i)           fix_o = lim_i;   // absent: take capability
    else if (rep_i > lim_i)   fix_o = lim_i;   // too large: clamp
    else if (rep_i == '0)     fix_o = MIN_V;   // zero: minimum code
    else                      fix_o = rep_i;
  end
endmodule

// File: rtl/link_sta_sync.sv
module link_sta_sync
  import lsync_pkg::*;
#(
  parameter logic [STA_W-1:0] RESET_STATUS = 16'hA411
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             dev_present_i,
  input  logic [STA_W-1:0] ds_sta_i,
  input  logic [CAP_W-1:0] cap_i,
  output logic [STA_W-1:0] lnk_sta_o
);
  localparam int SPD_HI = SPD_LSB + SPD_W - 1;
  localparam int WID_HI = WID_LSB + WID_W - 1;
  localparam logic [STA_W-1:0] FIELD_MASK =
    STA_W'(((1 << SPD_W) - 1) << SPD_LSB) | STA_W'(((1 << WID_W) - 1) << WID_LSB);

  logic [STA_W-1:0] sta_q, sta_nxt;
  logic [SPD_W-1:0] spd_fix;
  logic [WID_W-1:0] wid_fix;

  lsync_field_fix #(.W(SPD_W), .MIN_CODE(MIN_SPD)) u_spd (
    .present_i (dev_present_i),
    .rep_i     (ds_sta_i[SPD_HI:SPD_LSB]),
    .lim_i     (cap_i[SPD_HI:SPD_LSB]),
    .fix_o     (spd_fix)
  );

  lsync_field_fix #(.W(WID_W), .MIN_CODE(MIN_WID)) u_wid (
    .present_i (dev_present_i),
    .rep_i     (ds_sta_i[WID_HI:WID_LSB]),
    .lim_i     (cap_i[WID_HI:WID_LSB]),
    .fix_o     (wid_fix)
  );

  // Splice the two fixed fields into the current word.
  always_comb begin
    sta_nxt                  = sta_q;
    sta_nxt[SPD_HI:SPD_LSB]  = spd_fix;
    sta_nxt[WID_HI:WID_LSB]  = wid_fix;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     sta_q <= RESET_STATUS;
    else if (sync_i) sta_q <= sta_nxt;
  end

  assign lnk_sta_o = sta_q;

  // R10: no strobe, no change
  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(lnk_sta_o));

  // R9: bits outside the two fields never move
  assert_other_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(lnk_sta_o & ~FIELD_MASK));

  // R3: absent device reloads both fields from capability
  assert_absent_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !dev_present_i) |=>
      (lnk_sta_o[WID_HI:WID_LSB] == $past(cap_i[WID_HI:WID_LSB])) &&
      (lnk_sta_o[SPD_HI:SPD_LSB] == $past(cap_i[SPD_HI:SPD_LSB])));

  // R4: oversize width clamped
  assert_wid_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && dev_present_i && (ds_sta_i[WID_HI:WID_LSB] > cap_i[WID_HI:WID_LSB])) |=>
      (lnk_sta_o[WID_HI:WID_LSB] == $past(cap_i[WID_HI:WID_LSB])));

  // R5: zero width defaulted
  assert_wid_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && dev_present_i && (ds_sta_i[WID_HI:WID_LSB] == '0)) |=>
      (lnk_sta_o[WID_HI:WID_LSB] == WID_W'(MIN_WID)));

  // R6: oversize speed clamped
  assert_spd_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && dev_present_i && (ds_sta_i[SPD_HI:SPD_LSB] > cap_i[SPD_HI:SPD_LSB])) |=>
      (lnk_sta_o[SPD_HI:SPD_LSB] == $past(cap_i[SPD_HI:SPD_LSB])));

  // R7: zero speed defaulted
  assert_spd_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && dev_present_i && (ds_sta_i[SPD_HI:SPD_LSB] == '0)) |=>
      (lnk_sta_o[SPD_HI:SPD_LSB] == SPD_W'(MIN_SPD)));

  // R8: legal values pass through
  assert_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && dev_present_i && (ds_sta_i[WID_HI:WID_LSB] != '0) &&
     (ds_sta_i[WID_HI:WID_LSB] <= cap_i[WID_HI:WID_LSB])) |=>
      (lnk_sta_o[WID_HI:WID_LSB] == $past(ds_sta_i[WID_HI:WID_LSB])));
endmodule

// File: tb/link_sta_sync_bench.sv
module link_sta_sync_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync;
  logic        present;
  logic [15:0] ds_sta;
  logic [31:0] cap;
  logic [15:0] sta;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;  // 100 MHz

  link_sta_sync u_link_sta_sync (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sync_i        (sync),
    .dev_present_i (present),
    .ds_sta_i      (ds_sta),
    .cap_i         (cap),
    .lnk_sta_o     (sta)
  );

  // {present, downstream word, capability word, expected status}
  localparam int NV = 9;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 32'h0000_0083, 16'hA483},  // R3 absent: load w8 s3
    {1'b1, 16'h0042, 32'h0000_0083, 16'hA442},  // R8 in range
    {1'b1, 16'h0104, 32'h0000_0083, 16'hA483},  // R4 R6 clamp both
    {1'b1, 16'h0000, 32'h0000_0083, 16'hA411},  // R5 R7 zero defaults
    {1'b1, 16'hFC20, 32'h0000_00C5, 16'hA421},  // R9 upper ds bits ignored, R7
    {1'b1, 16'h03F9, 32'hFFFF_FC45, 16'hA445},  // R1 other cap bits ignored
    {1'b0, 16'h0000, 32'h0000_0000, 16'hA400},  // R3 absent, zero cap kept
    {1'b1, 16'h0010, 32'h0000_0000, 16'hA401},  // R4 clamp to 0, R7 default
    {1'b1, 16'h0083, 32'h0000_0083, 16'hA483}   // R8 equal to limit
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic p, input logic [15:0] d, input logic [31:0] c);
    @(negedge clk);
    present = p; ds_sta = d; cap = c; sync = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync = 1'b0; present = 1'b0; ds_sta = '0; cap = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset value", sta, 16'hA411);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after reset", sta, 16'hA411);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][64], VEC[i][63:48], VEC[i][47:16]);
      check($sformatf("vector %0d (R1 R3-R9)", i), sta, VEC[i][15:0]);
    end

    // R10: no strobe, inputs wiggle, register holds
    @(negedge clk);
    present = 1'b1; ds_sta = 16'h0021; cap = 32'h0000_0083;
    repeat (4) @(negedge clk);
    check("R10 idle hold", sta, 16'hA483);
    present = 1'b0; cap = 32'h0000_0011;
    @(negedge clk);
    check("R10 idle hold absent", sta, 16'hA483);

    // R10: value is old before the edge, new just after it
    present = 1'b1; ds_sta = 16'h0032; cap = 32'h0000_0083; sync = 1'b1;
    #1;
    check("R10 before edge", sta, 16'hA483);
    @(posedge clk);
    #1;
    check("R10 after edge", sta, 16'hA432);
    @(negedge clk);
    sync = 1'b0;

    // R2: mid-run reset restores default
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 mid-run reset", sta, 16'hA411);
    rst_n = 1'b1;

    // R5 R6: width zero defaults while speed clamps
    strobe(1'b1, 16'hFC0F, 32'h0000_0032);
    check("R5 R6 mixed", sta, 16'hA412);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule